// File: doc/BRIEF.md
# Port-Tagged Byte Stream Demultiplexer

This block sits on the host-to-device side of a multi-port serial bridge. A single byte channel carries both payload and control traffic for up to eight serial ports. Every record starts with a header byte. Bit 7 of that byte selects data (0) or command (1). Bits 2:0 name the target port, and bits 6:3 carry either the high bits of a payload length or a command code. The block walks this stream one byte at a time. It forwards each payload byte on a data output tagged with its port. It turns each command record into a one-cycle strobe of kind register-write, extended-command or skip.

Payload passes straight through without any register stage. While a payload byte waits on a stalled data output, the input is held back, so no byte is lost or reordered. Header, parameter and discarded bytes are always accepted at once. Each port has a transmit-credit input. A data segment that announces more bytes than its port's credit sets that port's sticky overflow flag. The segment is still consumed in full, so the stream stays framed.

The parser has seven named states. ST_HDR waits for a header. ST_LEN takes the low length byte. ST_DATA forwards payload. ST_PARAM takes the first parameter byte. ST_EXT_ARG takes the argument of an extended command. ST_VCOUNT takes the byte count of a variable-length record. ST_DROP discards bytes.

The transitions from ST_HDR are:
- a data header goes to ST_LEN
- a code of 0x0 to 0x7 or 0x9 goes to ST_PARAM
- a code of 0x8, 0xA or 0xB goes to ST_DROP with 2 bytes to discard
- a code of 0xC or 0xD goes to ST_DROP with 3 bytes to discard
- a code of 0xE or 0xF goes to ST_VCOUNT

The other transitions are:
- ST_LEN goes back to ST_HDR on a zero length, and otherwise to ST_DATA.
- ST_DATA returns to ST_HDR after its last byte.
- ST_PARAM returns to ST_HDR for a register write, and goes to ST_EXT_ARG for an extended command.
- ST_EXT_ARG returns to ST_HDR.
- ST_VCOUNT returns to ST_HDR on a zero count, and otherwise goes to ST_DROP.
- ST_DROP returns to ST_HDR after its last byte.

Top module: `port_stream_demux`

## Requirements
- R1: While reset is held and after it is released, in_ready is 1 and dout_valid, cmd_valid and every overflow bit are 0. The parser waits for a header.
- R2: In a header byte, bit 7 = 1 marks a command and bit 7 = 0 marks data. Bits 2:0 give the port, which appears on dout_port or cmd_port.
- R3: A data header is two bytes. The length is header bits 6:3 as bits 11:8 and the second byte as bits 7:0. Exactly that many following bytes appear on dout_data in order, with dout_last high on the final one.
- R4: A data header of length zero produces no payload, and the byte after it is parsed as a header.
- R5: A command code 0x0 to 0x7 is a two-byte record. One cycle after its second byte is accepted, cmd_valid pulses with cmd_kind = 0 (register write), cmd_code = the register number and cmd_param = the second byte.
- R6: Code 0x9 is a three-byte record. Its strobe carries cmd_kind = 1 (extended), cmd_sub = the second byte (sub-commands 0 to 9: open, close, drain, receive flow, transmit flow, XON char, XOFF char, checkpoint with sequence, break on, break off) and cmd_param = the third byte.
- R7: Codes 0x8, 0xA and 0xB are three-byte records that are discarded. The strobe after the last byte has cmd_kind = 2 (skip) and cmd_sub = cmd_param = 0.
- R8: Codes 0xC and 0xD are four-byte records that are discarded, with a skip strobe after the fourth byte.
- R9: For codes 0xE and 0xF, the second byte N counts the bytes after it. All N are discarded, and the skip strobe follows the last one, or the count byte itself when N = 0.
- R10: A data length greater than the port's credit (credit_i bits p*CREDIT_W upward) sets overflow bit p one cycle after the length byte is accepted. The bit stays set until reset, and the segment is still fully consumed. A length equal to the credit does not set it.
- R11: While a payload byte is offered and dout_ready is 0, in_ready is 0 and the byte is held.
- R12: cmd_valid is a single-cycle pulse. Header, length and command bytes never appear on the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte |
| credit_i | input | NPORTS*CREDIT_W | Per-port transmit credit, port p at bits p*CREDIT_W upward |
| dout_valid | output | 1 | Payload byte valid |
| dout_data | output | 8 | Payload byte |
| dout_port | output | 3 | Port of the payload byte |
| dout_last | output | 1 | Final byte of the segment |
| dout_ready | input | 1 | Downstream accepts the payload byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 2 | 0 register write, 1 extended, 2 skip |
| cmd_port | output | 3 | Port of the command |
| cmd_code | output | 4 | Header code bits |
| cmd_sub | output | 8 | Extended sub-command |
| cmd_param | output | 8 | Parameter byte |
| overflow_o | output | NPORTS | Sticky per-port credit overflow |

## Verification
Payload is combinational. dout_valid, dout_data, dout_port and dout_last are due in the same cycle as the offered byte. The bench therefore drives each byte on the falling edge and compares the data output one nanosecond later, before the rising edge that completes the handshake.

Command strobes and overflow flags are registered. They are due in the cycle after the record's final byte, or the length byte, is accepted. The bench posts an expectation on that acceptance and settles it at the next sample point. Any strobe at any other sample point is reported as unexpected.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int HDR_PORT_W = 3;
    localparam int CODE_W     = 4;
    localparam int LEN_W      = 12;
    localparam int BYTE_W     = 8;

    typedef enum logic [2:0] {
        ST_HDR, ST_LEN, ST_DATA, ST_PARAM, ST_EXT_ARG, ST_VCOUNT, ST_DROP
    } psd_state_e;

    typedef enum logic [1:0] {
        CK_REG  = 2'd0,
        CK_EXT  = 2'd1,
        CK_SKIP = 2'd2
    } psd_kind_e;

    typedef enum logic [2:0] {
        CL_DATA, CL_REG, CL_EXT, CL_RSV3, CL_FIX4, CL_VAR
    } psd_class_e;
endpackage

// File: rtl/psd_hdr_decode.sv
module psd_hdr_decode
    import psd_pkg::*;
(
    input  logic [BYTE_W-1:0]     hdr_byte,
    output psd_class_e            cls,
    output logic [CODE_W-1:0]     code,
    output logic [HDR_PORT_W-1:0] port
);
    always_comb begin
        code = hdr_byte[6:3];
        port = hdr_byte[2:0];
        if (!hdr_byte[7])           cls = CL_DATA;
        else if (code < 4'h8)       cls = CL_REG;
        else if (code == 4'h9)      cls = CL_EXT;
        else if (code <= 4'hB)      cls = CL_RSV3;
        else if (code <= 4'hD)      cls = CL_FIX4;
        else                        cls = CL_VAR;
    end
endmodule

// File: rtl/psd_down_counter.sv
module psd_down_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         at_one
);
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (dec)  count <= count - W'(1);
    end

    assign at_one = (count == W'(1));
endmodule

// File: rtl/psd_credit_guard.sv
module psd_credit_guard
    import psd_pkg::*;
#(
    parameter int NPORTS   = 8,
    parameter int CREDIT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chk_en,
    input  logic [HDR_PORT_W-1:0]      chk_port,
    input  logic [LEN_W-1:0]           chk_len,
    input  logic [NPORTS*CREDIT_W-1:0] credit_flat,
    output logic [NPORTS-1:0]          ovf_o
);
    localparam int CMP_W = (CREDIT_W > LEN_W) ? CREDIT_W : LEN_W;

    logic [NPORTS-1:0] exceed;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic [CREDIT_W-1:0] credit_g;
        assign credit_g  = credit_flat[g*CREDIT_W +: CREDIT_W];
        assign exceed[g] = chk_en && (chk_port == HDR_PORT_W'(g))
                           && (CMP_W'(chk_len) > CMP_W'(credit_g));

        always_ff @(posedge clk) begin
            if (!rst_n) ovf_o[g] <= 1'b0;
            else        ovf_o[g] <= ovf_o[g] | exceed[g];
        end
    end

    // R10: flags never clear outside reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_o) & ~ovf_o) == '0);
    // R10: a flag only changes after a length check
    a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o != $past(ovf_o)) |-> $past(chk_en));
endmodule

// File: rtl/port_stream_demux.sv
module port_stream_demux
    import psd_pkg::*;
#(
    parameter int NPORTS   = 8,
    parameter int CREDIT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [7:0]                 in_data,
    output logic                       in_ready,
    input  logic [NPORTS*CREDIT_W-1:0] credit_i,
    output logic                       dout_valid,
    output logic [7:0]                 dout_data,
    output logic [2:0]                 dout_port,
    output logic                       dout_last,
    input  logic                       dout_ready,
    output logic                       cmd_valid,
    output logic [1:0]                 cmd_kind,
    output logic [2:0]                 cmd_port,
    output logic [3:0]                 cmd_code,
    output logic [7:0]                 cmd_sub,
    output logic [7:0]                 cmd_param,
    output logic [NPORTS-1:0]          overflow_o
);
    psd_state_e              state_q, state_d;
    psd_class_e              dec_cls, cls_q;
    logic [CODE_W-1:0]       dec_code, code_q;
    logic [HDR_PORT_W-1:0]   dec_port, port_q;
    logic [BYTE_W-1:0]       sub_q;

    logic                    acc;
    logic                    cnt_load, cnt_dec, cnt_one;
    logic [LEN_W-1:0]        cnt_val, cnt_q;
    logic [LEN_W-1:0]        seg_len;
    logic                    chk_en;
    logic                    emit;
    psd_kind_e               emit_kind;
    psd_kind_e               kind_q;

    psd_hdr_decode u_dec (
        .hdr_byte (in_data),
        .cls      (dec_cls),
        .code     (dec_code),
        .port     (dec_port)
    );

    psd_down_counter #(.W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .count    (cnt_q),
        .at_one   (cnt_one)
    );

    psd_credit_guard #(.NPORTS(NPORTS), .CREDIT_W(CREDIT_W)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_en      (chk_en),
        .chk_port    (port_q),
        .chk_len     (seg_len),
        .credit_flat (credit_i),
        .ovf_o       (overflow_o)
    );

    // payload path is combinational; everything else is always accepted
    assign in_ready   = (state_q == ST_DATA) ? dout_ready : 1'b1;
    assign dout_valid = (state_q == ST_DATA) && in_valid;
    assign dout_data  = in_data;
    assign dout_port  = port_q;
    assign dout_last  = cnt_one;
    assign acc        = in_valid && in_ready;
    assign seg_len    = {code_q, in_data};

    // next state and control
    always_comb begin
        state_d   = state_q;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        cnt_dec   = 1'b0;
        chk_en    = 1'b0;
        emit      = 1'b0;
        emit_kind = CK_SKIP;
        unique case (state_q)
            ST_HDR: if (acc) begin
                unique case (dec_cls)
                    CL_DATA: state_d = ST_LEN;
                    CL_REG,
                    CL_EXT:  state_d = ST_PARAM;
                    CL_RSV3: begin
                        cnt_load = 1'b1;
                        cnt_val  = LEN_W'(2);
                        state_d  = ST_DROP;
                    end
                    CL_FIX4: begin
                        cnt_load = 1'b1;
                        cnt_val  = LEN_W'(3);
                        state_d  = ST_DROP;
                    end
                    CL_VAR:  state_d = ST_VCOUNT;
                    default: state_d = ST_HDR;
                endcase
            end
            ST_LEN: if (acc) begin
                chk_en = 1'b1;
                if (seg_len == '0) begin
                    state_d = ST_HDR;
                end else begin
                    cnt_load = 1'b1;
                    cnt_val  = seg_len;
                    state_d  = ST_DATA;
                end
            end
            ST_DATA: if (acc) begin
                cnt_dec = 1'b1;
                if (cnt_one) state_d = ST_HDR;
            end
            ST_PARAM: if (acc) begin
                if (cls_q == CL_REG) begin
                    emit      = 1'b1;
                    emit_kind = CK_REG;
                    state_d   = ST_HDR;
                end else begin
                    state_d = ST_EXT_ARG;
                end
            end
            ST_EXT_ARG: if (acc) begin
                emit      = 1'b1;
                emit_kind = CK_EXT;
                state_d   = ST_HDR;
            end
            ST_VCOUNT: if (acc) begin
                if (in_data == '0) begin
                    emit    = 1'b1;
                    state_d = ST_HDR;
                end else begin
                    cnt_load = 1'b1;
                    cnt_val  = LEN_W'(in_data);
                    state_d  = ST_DROP;
                end
            end
            ST_DROP: if (acc) begin
                cnt_dec = 1'b1;
                if (cnt_one) begin
                    emit    = 1'b1;
                    state_d = ST_HDR;
                end
            end
            default: state_d = ST_HDR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HDR;
        else        state_q <= state_d;
    end

    // header and sub-command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= CL_DATA;
            code_q <= '0;
            port_q <= '0;
            sub_q  <= '0;
        end else if (acc) begin
            if (state_q == ST_HDR) begin
                cls_q  <= dec_cls;
                code_q <= dec_code;
                port_q <= dec_port;
            end
            if (state_q == ST_PARAM) sub_q <= in_data;
        end
    end

    // command strobe outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            kind_q    <= CK_SKIP;
            cmd_port  <= '0;
            cmd_code  <= '0;
            cmd_sub   <= '0;
            cmd_param <= '0;
        end else begin
            cmd_valid <= emit;
            if (emit) begin
                kind_q    <= emit_kind;
                cmd_port  <= port_q;
                cmd_code  <= code_q;
                cmd_sub   <= (emit_kind == CK_EXT) ? sub_q : '0;
                cmd_param <= (emit_kind == CK_SKIP) ? '0 : in_data;
            end
        end
    end

    assign cmd_kind = kind_q;

    // R12: strobe lasts one cycle
    a_r12_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R12: strobe only follows an accepted byte
    a_r12_cmd_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(in_valid && in_ready));
    // R5: register writes carry codes 0..7
    a_r5_reg_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd0) |-> (cmd_code < 4'h8));
    // R6: extended strobes carry code 9
    a_r6_ext_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd1) |-> (cmd_code == 4'h9));
    // R3: after the last payload byte no payload is offered
    a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && dout_ready && dout_last) |=> !dout_valid);
endmodule

// File: tb/port_stream_demux_tb.sv
`timescale 1ns/1ps
module port_stream_demux_tb;
    localparam int NPORTS   = 8;
    localparam int CREDIT_W = 16;
    localparam int MAXB     = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready;
    logic [NPORTS*CREDIT_W-1:0] credit_i;
    logic dout_valid, dout_last, cmd_valid;
    logic [7:0] dout_data, cmd_sub, cmd_param;
    logic [2:0] dout_port, cmd_port;
    logic [1:0] cmd_kind;
    logic [3:0] cmd_code;
    logic dout_ready = 1'b1;
    logic [NPORTS-1:0] overflow_o;

    always #2 clk = ~clk;

    port_stream_demux #(.NPORTS(NPORTS), .CREDIT_W(CREDIT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .credit_i(credit_i), .dout_valid(dout_valid),
        .dout_data(dout_data), .dout_port(dout_port), .dout_last(dout_last),
        .dout_ready(dout_ready), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_port(cmd_port), .cmd_code(cmd_code), .cmd_sub(cmd_sub),
        .cmd_param(cmd_param), .overflow_o(overflow_o)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] sb[MAXB];
    bit         spay[MAXB];
    logic [2:0] sport[MAXB];
    bit         slast[MAXB];
    bit         scend[MAXB];
    int         sovf[MAXB];
    string      stag[MAXB];
    logic [1:0] ckind[MAXB];
    logic [2:0] cport[MAXB];
    logic [3:0] ccode[MAXB];
    logic [7:0] csub[MAXB];
    logic [7:0] cparam[MAXB];
    int nb = 0;
    string next_hdr_tag = "R2";

    function automatic logic [15:0] credit_of(input int p);
        return (p == 3) ? 16'd4 : 16'd4095;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input bit pay, input logic [2:0] p,
                        input bit last, input string tag);
        sb[nb] = b; spay[nb] = pay; sport[nb] = p; slast[nb] = last;
        scend[nb] = 1'b0; sovf[nb] = -1; stag[nb] = tag;
        nb++;
    endtask

    task automatic push_hdr(input logic [7:0] b);
        push(b, 1'b0, 3'd0, 1'b0, next_hdr_tag);
        next_hdr_tag = "R2";
    endtask

    task automatic mark_cmd(input logic [1:0] k, input logic [2:0] p,
                            input logic [3:0] c, input logic [7:0] s,
                            input logic [7:0] v, input string tag);
        scend[nb-1] = 1'b1; ckind[nb-1] = k; cport[nb-1] = p;
        ccode[nb-1] = c; csub[nb-1] = s; cparam[nb-1] = v; stag[nb-1] = tag;
    endtask

    task automatic add_data(input logic [2:0] p, input logic [11:0] len);
        push_hdr({1'b0, len[11:8], p});
        push(len[7:0], 1'b0, 3'd0, 1'b0, "R3");
        if (32'(len) > 32'(credit_of(int'(p)))) sovf[nb-1] = int'(p);
        for (int i = 0; i < int'(len); i++)
            push(8'($urandom), 1'b1, p, (i == int'(len) - 1), "R3");
        if (len == 12'd0) next_hdr_tag = "R4";
    endtask

    task automatic add_reg(input logic [2:0] p, input logic [2:0] r, input logic [7:0] v);
        push_hdr({1'b1, 1'b0, r, p});
        push(v, 1'b0, 3'd0, 1'b0, "R12");
        mark_cmd(2'd0, p, {1'b0, r}, 8'd0, v, "R5");
    endtask

    task automatic add_ext(input logic [2:0] p, input logic [7:0] s, input logic [7:0] v);
        push_hdr({1'b1, 4'h9, p});
        push(s, 1'b0, 3'd0, 1'b0, "R12");
        push(v, 1'b0, 3'd0, 1'b0, "R12");
        mark_cmd(2'd1, p, 4'h9, s, v, "R6");
    endtask

    task automatic add_skip(input logic [2:0] p, input logic [3:0] c, input int n);
        push_hdr({1'b1, c, p});
        if (c >= 4'hE) begin
            push(8'(n), 1'b0, 3'd0, 1'b0, "R12");
            for (int i = 0; i < n; i++) push(8'($urandom), 1'b0, 3'd0, 1'b0, "R12");
            mark_cmd(2'd2, p, c, 8'd0, 8'd0, "R9");
        end else begin
            for (int i = 0; i < n; i++) push(8'($urandom), 1'b0, 3'd0, 1'b0, "R12");
            mark_cmd(2'd2, p, c, 8'd0, 8'd0, (c >= 4'hC) ? "R8" : "R7");
        end
    endtask

    always_comb
        for (int p = 0; p < NPORTS; p++)
            credit_i[p*CREDIT_W +: CREDIT_W] = credit_of(p);

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int idx;
        bit cpend;
        int cidx;
        logic [NPORTS-1:0] exp_ovf, ovf_pend;
        bit force_stall;
        void'($urandom(32'd2024));

        // directed records
        add_data(3'd3, 12'd4);                 // equal to credit, no overflow
        add_data(3'd1, 12'd0);                 // zero length
        add_data(3'd7, 12'h123);               // 12-bit length
        for (int r = 0; r < 8; r++) add_reg(3'(r), 3'(r), 8'(8'hA0 + r));
        for (int s = 0; s < 10; s++) add_ext(3'(s % 8), 8'(s), 8'(8'h50 + s));
        add_skip(3'd2, 4'h8, 2);
        add_skip(3'd4, 4'hA, 2);
        add_skip(3'd5, 4'hB, 2);
        add_skip(3'd6, 4'hC, 3);
        add_skip(3'd0, 4'hD, 3);
        add_skip(3'd1, 4'hE, 0);
        add_skip(3'd2, 4'hF, 5);
        add_data(3'd3, 12'd6);                 // exceeds credit
        add_data(3'd0, 12'd0);
        add_reg(3'd5, 3'd2, 8'h33);
        // random records
        for (int k = 0; k < 70; k++) begin
            int sel = int'($urandom % 6);
            logic [2:0] p = 3'($urandom);
            case (sel)
                0, 1: add_data(p, 12'($urandom % 40));
                2:    add_reg(p, 3'($urandom), 8'($urandom));
                3:    add_ext(p, 8'($urandom % 10), 8'($urandom));
                4:    add_skip(p, 4'hE + 4'($urandom % 2), int'($urandom % 6));
                default: add_skip(p, 4'hC, 3);
            endcase
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        check(cmd_valid == 1'b0, "R1", "cmd_valid in reset", int'(cmd_valid), 0);
        check(overflow_o == '0, "R1", "overflow in reset", int'(overflow_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(dout_valid == 1'b0, "R1", "dout_valid after reset", int'(dout_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        idx = 0; cpend = 1'b0; cidx = 0; exp_ovf = '0; ovf_pend = '0;
        while (idx < nb || cpend || ovf_pend != '0) begin
            @(negedge clk);
            force_stall = (idx >= 10 && idx < 40);
            in_valid   = (idx < nb) && ($urandom % 5 != 0);
            in_data    = (idx < nb) ? sb[idx] : 8'h00;
            dout_ready = force_stall ? ($urandom % 3 == 0) : ($urandom % 4 != 0);
            #1;
            exp_ovf = exp_ovf | ovf_pend;
            ovf_pend = '0;
            check(overflow_o == exp_ovf, "R10", "overflow flags",
                  int'(overflow_o), int'(exp_ovf));
            if (cpend) begin
                check(cmd_valid == 1'b1, stag[cidx], "cmd_valid", int'(cmd_valid), 1);
                check(cmd_kind == ckind[cidx] && cmd_port == cport[cidx] &&
                      cmd_code == ccode[cidx], stag[cidx], "kind/port/code",
                      int'({cmd_kind, cmd_port, cmd_code}),
                      int'({ckind[cidx], cport[cidx], ccode[cidx]}));
                check(cmd_sub == csub[cidx] && cmd_param == cparam[cidx], stag[cidx],
                      "sub/param", int'({cmd_sub, cmd_param}),
                      int'({csub[cidx], cparam[cidx]}));
                cpend = 1'b0;
            end else begin
                check(cmd_valid == 1'b0, "R12", "unexpected strobe", int'(cmd_valid), 0);
            end
            if (idx < nb && in_valid) begin
                if (spay[idx]) begin
                    check(dout_valid && dout_data == sb[idx], "R3", "payload byte",
                          int'(dout_data), int'(sb[idx]));
                    check(dout_port == sport[idx], "R2", "payload port",
                          int'(dout_port), int'(sport[idx]));
                    check(dout_last == slast[idx], "R3", "last flag",
                          int'(dout_last), int'(slast[idx]));
                    if (!dout_ready)
                        check(in_ready == 1'b0, "R11", "stall in_ready", int'(in_ready), 0);
                end else begin
                    check(dout_valid == 1'b0, stag[idx], "non-payload on data output",
                          int'(dout_valid), 0);
                    check(in_ready == 1'b1, stag[idx], "non-payload accepted",
                          int'(in_ready), 1);
                end
                if (in_ready) begin
                    if (scend[idx]) begin cpend = 1'b1; cidx = idx; end
                    if (sovf[idx] >= 0) ovf_pend[sovf[idx]] = 1'b1;
                    idx++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(cmd_valid == 1'b0, "R12", "idle strobe", int'(cmd_valid), 0);
        check(overflow_o == 8'h08, "R10", "final overflow", int'(overflow_o), 8);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule